// File: doc/BRIEF.md
# Cartridge Memory Bank Mapper

This block lets an 8-bit processor with a 16-bit address bus reach a cartridge that holds up to 1MB of ROM and 32KB of battery-backed SRAM. The lower 48KB of the processor's address space is divided into three 16KB windows. Each window is backed by a 6-bit page register that selects one of 64 ROM pages of 16KB. A control register can place SRAM over the third window. It can also enable SRAM in the top 16KB of the address space. The first 1KB always reads the start of ROM, so the processor's restart and interrupt entry points stay fixed whatever paging the software selects.

The mapper listens to ordinary memory writes aimed at the four highest addresses. Those addresses lie inside the console's RAM mirror, so the same write also lands in system RAM, and software reads the values back from there. The mapper has no read path of its own. Address translation and chip-select generation are purely combinational from the current address and the stored registers. A register write takes effect on the very next access. All pins are plain level signals: there is no streaming data path and no back-pressure.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset the three window page registers hold 0, 1 and 2. A read at 0x1234 gives ROM address 0x01234, a read at 0x4123 gives 0x04123 and a read at 0x8ABC gives 0x08ABC.
- R2: A register is written only on a rising clock edge where `cpu_mreq` and `cpu_wr` are both 1 and address bits 15:2 are all ones. The low address bits 1:0 choose the register: 0 selects control, and 1, 2 and 3 select the page registers of windows 0, 1 and 2. Writes anywhere else, or writes with `cpu_mreq` low, change nothing.
- R3: For an address in window n (address bits 15:14 equal to n, with n from 0 to 2), `rom_addr` is {page_n[5:0], cpu_addr[13:0]}. Only data bits 5:0 are kept when a page register is written.
- R4: Addresses 0x0000–0x03FF give `rom_addr` equal to the CPU address, whatever window 0's page register holds. Address 0x0400 and above in window 0 use that page register.
- R5: When control bit 3 is 1, an access to window 2 (0x8000–0xBFFF) asserts `ram_cs` and does not assert `rom_cs`. The window 2 page register is ignored in that case.
- R6: During the window 2 overlay, `ram_addr` is {control bit 2, cpu_addr[13:0]}. Bit 2 = 0 selects the lower SRAM half and bit 2 = 1 selects the upper half.
- R7: When control bit 4 is 1, an access at 0xC000–0xFFFF asserts `ram_cs` with `ram_addr` = {0, cpu_addr[13:0]}. When bit 4 is 0, that range asserts no chip select.
- R8: Control bits 7, 6, 5, 1 and 0 have no effect on any output.
- R9: `rom_cs` is 1 only for a read (`cpu_rd`=1, `cpu_mreq`=1) below 0xC000 that is not overlaid by SRAM. `ram_cs` needs `cpu_mreq`=1 together with a read or a write. With `cpu_mreq`=0 both chip selects are 0.
- R10: Outputs follow the address in the same cycle. A register write captured at one clock edge already governs an access presented right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; registers capture on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_mreq | input | 1 | Memory request, active high |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| rom_addr | output | 20 | Translated ROM byte address |
| ram_addr | output | 15 | Translated SRAM byte address |
| rom_cs | output | 1 | ROM chip select, active high |
| ram_cs | output | 1 | SRAM chip select, active high |

## Verification
Translated addresses and chip selects are combinational, so they are due in the same cycle as the address. The bench drives each access on a falling edge and samples one nanosecond later, well before the next rising edge. A register write becomes visible one rising edge after it is presented. Each write task holds the strobe across exactly one rising edge and then drops it. The following probe on the next falling edge is therefore the first access that can see the new value, which exercises the no-delay rule directly.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  typedef enum logic [1:0] {
    WIN0   = 2'd0,
    WIN1   = 2'd1,
    WIN2   = 2'd2,
    WIN_HI = 2'd3
  } win_e;

  // control register field positions decoded by the translator
  localparam int CTL_HALF = 2;
  localparam int CTL_OVL  = 3;
  localparam int CTL_HI   = 4;
endpackage

// File: rtl/cbm_regs.sv
module cbm_regs
  import cbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 6,
  parameter int NWIN   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  input  logic                         mreq,
  input  logic                         wr,
  output logic [NWIN-1:0][BANK_W-1:0]  page,
  output logic                         ctl_half,
  output logic                         ctl_ovl,
  output logic                         ctl_hi
);
  logic hit;
  logic unused_wdata;

  assign hit          = mreq & wr & (&addr[ADDR_W-1:2]);
  assign unused_wdata = ^wdata[DATA_W-1:BANK_W];

  for (genvar i = 0; i < NWIN; i++) begin : g_page
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        page[i] <= BANK_W'(i);
      else if (hit && addr[1:0] == 2'(i + 1))
        page[i] <= wdata[BANK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_half <= 1'b0;
      ctl_ovl  <= 1'b0;
      ctl_hi   <= 1'b0;
    end else if (hit && addr[1:0] == 2'd0) begin
      ctl_half <= wdata[CTL_HALF];
      ctl_ovl  <= wdata[CTL_OVL];
      ctl_hi   <= wdata[CTL_HI];
    end
  end
endmodule

// File: rtl/cbm_win_dec.sv
module cbm_win_dec
  import cbm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 14,
  parameter int VEC_W  = 10
) (
  input  logic [ADDR_W-1:0] addr,
  output win_e              win,
  output logic              in_vec
);
  assign win    = win_e'(addr[ADDR_W-1:PAGE_W]);
  assign in_vec = (addr[ADDR_W-1:VEC_W] == '0);
endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate
  import cbm_pkg::*;
#(
  parameter int  ADDR_W = 16,
  parameter int  PAGE_W = 14,
  parameter int  BANK_W = 6,
  parameter int  NWIN   = 3,
  localparam int ROM_AW = BANK_W + PAGE_W,
  localparam int RAM_AW = 1 + PAGE_W
) (
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        mreq,
  input  logic                        rd,
  input  logic                        wr,
  input  win_e                        win,
  input  logic                        in_vec,
  input  logic [NWIN-1:0][BANK_W-1:0] page,
  input  logic                        ctl_half,
  input  logic                        ctl_ovl,
  input  logic                        ctl_hi,
  output logic [ROM_AW-1:0]           rom_addr,
  output logic [RAM_AW-1:0]           ram_addr,
  output logic                        rom_cs,
  output logic                        ram_cs
);
  logic [BANK_W-1:0] rom_page;
  logic              ovl_hit;
  logic              hi_hit;

  always_comb begin
    case (win)
      WIN0:    rom_page = in_vec ? '0 : page[0];
      WIN1:    rom_page = page[1];
      WIN2:    rom_page = page[2];
      default: rom_page = '0;
    endcase
  end

  assign ovl_hit  = (win == WIN2) && ctl_ovl;
  assign hi_hit   = (win == WIN_HI) && ctl_hi;
  assign rom_addr = {rom_page, addr[PAGE_W-1:0]};
  assign ram_addr = {ovl_hit & ctl_half, addr[PAGE_W-1:0]};
  assign rom_cs   = mreq & rd & (win != WIN_HI) & ~ovl_hit;
  assign ram_cs   = mreq & (rd | wr) & (ovl_hit | hi_hit);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cbm_pkg::*;
#(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 8,
  parameter int  PAGE_W = 14,
  parameter int  BANK_W = 6,
  parameter int  VEC_W  = 10,
  localparam int NWIN   = 3,
  localparam int ROM_AW = BANK_W + PAGE_W,
  localparam int RAM_AW = 1 + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_mreq,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              rom_cs,
  output logic              ram_cs
);
  logic [NWIN-1:0][BANK_W-1:0] page;
  logic                        ctl_half, ctl_ovl, ctl_hi;
  win_e                        win;
  logic                        in_vec;

  cbm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .NWIN(NWIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(cpu_addr), .wdata(cpu_wdata),
    .mreq(cpu_mreq), .wr(cpu_wr), .page(page),
    .ctl_half(ctl_half), .ctl_ovl(ctl_ovl), .ctl_hi(ctl_hi)
  );

  cbm_win_dec #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .VEC_W(VEC_W)) u_dec (
    .addr(cpu_addr), .win(win), .in_vec(in_vec)
  );

  cbm_xlate #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .NWIN(NWIN)) u_xl (
    .addr(cpu_addr), .mreq(cpu_mreq), .rd(cpu_rd), .wr(cpu_wr),
    .win(win), .in_vec(in_vec), .page(page),
    .ctl_half(ctl_half), .ctl_ovl(ctl_ovl), .ctl_hi(ctl_hi),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .rom_cs(rom_cs), .ram_cs(ram_cs)
  );
endmodule

// File: rtl/cbm_chk.sv
module cbm_chk #(
  parameter int  ADDR_W = 16,
  parameter int  PAGE_W = 14,
  parameter int  BANK_W = 6,
  parameter int  VEC_W  = 10,
  localparam int ROM_AW = BANK_W + PAGE_W,
  localparam int RAM_AW = 1 + PAGE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_mreq,
  input logic              cpu_rd,
  input logic              cpu_wr,
  input logic [ROM_AW-1:0] rom_addr,
  input logic [RAM_AW-1:0] ram_addr,
  input logic              rom_cs,
  input logic              ram_cs
);
  logic reg_wr;
  assign reg_wr = cpu_mreq & cpu_wr & (&cpu_addr[ADDR_W-1:2]);

  AST_CS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs)); // R5

  AST_VEC_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1:VEC_W] == '0) |-> (rom_addr == ROM_AW'(cpu_addr))); // R4

  AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_mreq |-> (!rom_cs && !ram_cs)); // R9

  AST_TOP_NO_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1:PAGE_W] == 2'd3) |-> !rom_cs); // R9

  AST_MAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_wr) && $stable(cpu_addr)) |-> ($stable(rom_addr) && $stable(ram_addr))); // R2

  AST_OVL_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_cs && cpu_addr[ADDR_W-1:PAGE_W] == 2'd2) |->
      (ram_addr[PAGE_W-1:0] == cpu_addr[PAGE_W-1:0])); // R6
endmodule

bind cart_bank_mapper cbm_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BANK_W(BANK_W), .VEC_W(VEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_mreq(cpu_mreq),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr), .ram_addr(ram_addr),
  .rom_cs(rom_cs), .ram_cs(ram_cs)
);

// File: tb/sim_cart_bank_mapper.sv
`timescale 1ns/1ps
module sim_cart_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        cpu_mreq = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [19:0] rom_addr;
  logic [14:0] ram_addr;
  logic        rom_cs, ram_cs;
  int          total = 0, bad = 0, cycles = 0;

  always #2 clk = ~clk;

  cart_bank_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_mreq(cpu_mreq), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .rom_cs(rom_cs), .ram_cs(ram_cs)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one write cycle held across a single rising edge
  task automatic wr_cyc(input logic [15:0] a, input logic [7:0] d, input logic mq);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_mreq = mq; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(posedge clk);
    #1;
    cpu_wr = 1'b0; cpu_mreq = 1'b0;
  endtask

  task automatic access(input logic [15:0] a, input logic mq, input logic rd, input logic wr);
    @(negedge clk);
    cpu_addr = a; cpu_mreq = mq; cpu_rd = rd; cpu_wr = wr;
    #1;
  endtask

  task automatic t_reset;
    access(16'h1234, 1, 1, 0); chk("R1 win0 reset", rom_addr, 20'h01234);
    chk("R9 rom_cs read", rom_cs, 1);
    access(16'h4123, 1, 1, 0); chk("R1 win1 reset", rom_addr, 20'h04123);
    access(16'h8ABC, 1, 1, 0); chk("R1 win2 reset", rom_addr, 20'h08ABC);
    chk("R1 no ram_cs", ram_cs, 0);
  endtask

  task automatic t_pages;
    wr_cyc(16'hFFFE, 8'h12, 1);
    access(16'h4000, 1, 1, 0); chk("R10 R3 win1 page 0x12", rom_addr, 20'h48000);
    wr_cyc(16'hFFFF, 8'hFF, 1);
    access(16'h8001, 1, 1, 0); chk("R3 win2 six bits kept", rom_addr, 20'hFC001);
    wr_cyc(16'hFFFD, 8'h05, 1);
    access(16'h0400, 1, 1, 0); chk("R4 R3 win0 above vectors", rom_addr, 20'h14400);
  endtask

  task automatic t_vectors;
    access(16'h03FF, 1, 1, 0); chk("R4 vector top", rom_addr, 20'h003FF);
    access(16'h0000, 1, 1, 0); chk("R4 vector base", rom_addr, 20'h00000);
  endtask

  task automatic t_ignored;
    wr_cyc(16'hFFFB, 8'h1C, 1);
    access(16'h8002, 1, 1, 0); chk("R2 0xFFFB no overlay", ram_cs, 0);
    chk("R2 0xFFFB page kept", rom_addr, 20'hFC002);
    wr_cyc(16'hFFFF, 8'h07, 0);
    access(16'h8003, 1, 1, 0); chk("R2 no mreq page kept", rom_addr, 20'hFC003);
    wr_cyc(16'h7FFF, 8'h09, 1);
    access(16'h4004, 1, 1, 0); chk("R2 0x7FFF win1 kept", rom_addr, 20'h48004);
  endtask

  task automatic t_overlay;
    wr_cyc(16'hFFFC, 8'h08, 1);
    access(16'h8010, 1, 1, 0);
    chk("R5 ram_cs", ram_cs, 1); chk("R5 rom_cs off", rom_cs, 0);
    chk("R6 lower half", ram_addr, 15'h0010);
    wr_cyc(16'hFFFC, 8'h0C, 1);
    access(16'h8010, 1, 1, 0); chk("R6 upper half", ram_addr, 15'h4010);
    access(16'hBFFF, 1, 0, 1); chk("R9 R5 ram write", ram_cs, 1);
    access(16'h4010, 1, 1, 0); chk("R5 win1 still rom", rom_cs, 1);
    access(16'hC010, 1, 1, 0); chk("R7 top off", ram_cs, 0);
  endtask

  task automatic t_top;
    wr_cyc(16'hFFFC, 8'h10, 1);
    access(16'hC123, 1, 1, 0); chk("R7 top ram_cs", ram_cs, 1);
    chk("R7 top addr", ram_addr, 15'h0123); chk("R9 top rom_cs", rom_cs, 0);
    access(16'h8005, 1, 1, 0); chk("R7 win2 back to rom", rom_cs, 1);
    wr_cyc(16'hFFFC, 8'h14, 1);
    access(16'hC123, 1, 1, 0); chk("R7 top bit14 zero", ram_addr, 15'h0123);
    wr_cyc(16'hFFFC, 8'h00, 1);
    access(16'hC123, 1, 1, 0); chk("R7 top disabled", ram_cs, 0);
  endtask

  task automatic t_inert_bits;
    wr_cyc(16'hFFFC, 8'hE3, 1);
    access(16'h8006, 1, 1, 0); chk("R8 win2 rom", rom_addr, 20'hFC006);
    chk("R8 win2 rom_cs", rom_cs, 1); chk("R8 win2 no ram", ram_cs, 0);
    access(16'hC000, 1, 1, 0); chk("R8 top no ram", ram_cs, 0);
  endtask

  task automatic t_gating;
    access(16'h4000, 0, 1, 0); chk("R9 no mreq rom", rom_cs, 0);
    chk("R9 no mreq ram", ram_cs, 0);
    access(16'h4000, 1, 0, 1); chk("R9 write no rom_cs", rom_cs, 0);
    access(16'h4000, 1, 0, 0); chk("R9 no strobe", rom_cs, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_pages();
    t_vectors();
    t_ignored();
    t_overlay();
    t_top();
    t_inert_bits();
    t_gating();
    // second reset restores the power-up pages
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule